// File: doc/BRIEF.md
# Address-Decoded Output Latch Bank

This block is a bank of eight byte-wide output ports that sits on a 16-bit multiplexed address/data bus. During the address phase of a bus cycle the block captures the bus word. During the data phase it watches an active-low write strobe and a memory/IO qualifier, where 0 marks an I/O cycle. When an I/O write falls inside the bank's address window, the low byte of the bus is loaded into one of eight output latches. The latch is chosen by three address bits. The latches together drive 64 output lines, and each line keeps its value until software writes to the same port again.

The bank answers only at even addresses in the upper half of the I/O space: address bit 0 must be 0 and bit 15 must be 1. Address bits 3 to 1 give the port number, so the ports lie two addresses apart from 8000h to 800Eh. Bits 14 to 4 are not decoded. An asynchronous active-low reset clears every port, and its release is synchronised to the clock internally.

Top module: `io_out_latch_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every output line reads 0 until the first accepted write.
- R2: The bus word is captured on each clock where `ale` is 1 and is held after `ale` falls. Bus values during the data phase do not change which port is selected, nor whether the bank responds.
- R3: A cycle with `mem_io` = 1 (a memory cycle) never changes any output.
- R4: The port number is captured address bits [3:1], so 8000h selects port 0, 8002h port 1 and 800Eh port 7. Bits [14:4] are ignored, so FFF0h selects port 0.
- R5: A captured address with bit 0 = 1 or bit 15 = 0 never changes any output.
- R6: Port i drives `port_q[8*i+7:8*i]`, and a write changes no more than the one selected port.
- R7: A port keeps its value across writes to other ports and across idle cycles, and a later write to the same port replaces it.
- R8: An accepted write loads `ad[7:0]` on the clock edge at which `wr_n` is sampled 0, and the new value is on the outputs right after that edge.
- R9: On cycles with `wr_n` = 1 the outputs do not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address phase marker, 1 while the bus carries the address |
| mem_io | input | 1 | Cycle kind: 1 memory, 0 I/O |
| wr_n | input | 1 | Active-low write strobe; write data is valid while it is 0 |
| ad | input | 16 | Multiplexed address/data bus |
| port_q | output | 64 | Eight output ports, port i on bits 8*i+7 to 8*i |

## Verification
The address register loads on the edge that samples `ale` high and is used from the next edge onward. A write lands on the outputs at the same edge that samples `wr_n` low, so each result is due within one clock of its stimulus. The bench drives inputs on falling edges. Its behavioural model updates on rising edges, and the outputs are compared with the model on every falling edge, half a cycle after each result is due. Directed checks after each bus cycle confirm the decode, the rejected cycles and the holding of values.

// File: rtl/iolb_pkg.sv
package iolb_pkg;
  localparam int unsigned IOLB_ADDR_W   = 16;
  localparam int unsigned IOLB_PORTS    = 8;
  localparam int unsigned IOLB_PORT_W   = 8;
  localparam int unsigned IOLB_SEL_LSB  = 1;
  localparam logic [IOLB_ADDR_W-1:0] IOLB_DEC_MASK  = 16'h8001;
  localparam logic [IOLB_ADDR_W-1:0] IOLB_DEC_MATCH = 16'h8000;

  typedef enum logic {CYC_IO = 1'b0, CYC_MEM = 1'b1} cyc_kind_e;
endpackage

// File: rtl/iolb_rst_sync.sv
module iolb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iolb_addr_capture.sv
module iolb_addr_capture #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] bus,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (cap_en) addr_d = bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/iolb_port_decode.sv
module iolb_port_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned PORTS   = 8,
  parameter int unsigned SEL_LSB = 1,
  parameter logic [ADDR_W-1:0] DEC_MASK  = 16'h8001,
  parameter logic [ADDR_W-1:0] DEC_MATCH = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_cycle,
  input  logic              wr_active,
  output logic [PORTS-1:0]  load_en
);
  localparam int unsigned SEL_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic             window_hit;
  logic             accept;
  logic [SEL_W-1:0] sel;

  always_comb begin
    window_hit = ((addr & DEC_MASK) == DEC_MATCH);
    accept     = window_hit && io_cycle && wr_active;
    sel        = addr[SEL_LSB +: SEL_W];
  end

  for (genvar gi = 0; gi < PORTS; gi++) begin : g_dec
    assign load_en[gi] = accept && (sel == SEL_W'(gi));
  end
endmodule

// File: rtl/iolb_out_latch.sv
module iolb_out_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/io_out_latch_bank.sv
module io_out_latch_bank
  import iolb_pkg::*;
#(
  parameter int unsigned ADDR_W  = IOLB_ADDR_W,
  parameter int unsigned PORTS   = IOLB_PORTS,
  parameter int unsigned PORT_W  = IOLB_PORT_W,
  parameter int unsigned SEL_LSB = IOLB_SEL_LSB,
  parameter logic [ADDR_W-1:0] DEC_MASK  = IOLB_DEC_MASK,
  parameter logic [ADDR_W-1:0] DEC_MATCH = IOLB_DEC_MATCH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ale,
  input  logic                    mem_io,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       ad,
  output logic [PORTS*PORT_W-1:0] port_q
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_q;
  logic [PORTS-1:0]  load_en;
  logic              io_cycle;

  assign io_cycle = (cyc_kind_e'(mem_io) == CYC_IO);

  iolb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  iolb_addr_capture #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(ale), .bus(ad), .addr_q(addr_q)
  );

  iolb_port_decode #(
    .ADDR_W(ADDR_W), .PORTS(PORTS), .SEL_LSB(SEL_LSB),
    .DEC_MASK(DEC_MASK), .DEC_MATCH(DEC_MATCH)
  ) u_dec (
    .addr(addr_q), .io_cycle(io_cycle), .wr_active(!wr_n), .load_en(load_en)
  );

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
    iolb_out_latch #(.WIDTH(PORT_W)) u_latch (
      .clk(clk), .rst_n(rst_sync_n), .load(load_en[gp]),
      .d(ad[PORT_W-1:0]), .q(port_q[gp*PORT_W +: PORT_W])
    );
  end
endmodule

// File: rtl/iolb_checker.sv
module iolb_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PORTS  = 8,
  parameter int unsigned PORT_W = 8,
  parameter logic [ADDR_W-1:0] DEC_MASK  = 16'h8001,
  parameter logic [ADDR_W-1:0] DEC_MATCH = 16'h8000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mem_io,
  input logic                    wr_n,
  input logic [ADDR_W-1:0]       addr_q,
  input logic [PORTS*PORT_W-1:0] port_q
);
  logic [PORTS*PORT_W-1:0] prev_q;
  logic [PORTS-1:0]        byte_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= port_q;
  end

  for (genvar gb = 0; gb < PORTS; gb++) begin : g_chg
    assign byte_chg[gb] = (port_q[gb*PORT_W +: PORT_W] != prev_q[gb*PORT_W +: PORT_W]);
  end

  p_mem_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_io |=> $stable(port_q));

  p_outside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_q & DEC_MASK) != DEC_MATCH) |=> $stable(port_q));

  p_single_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(byte_chg));

  p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(port_q));
endmodule

bind io_out_latch_bank iolb_checker #(
  .ADDR_W(ADDR_W), .PORTS(PORTS), .PORT_W(PORT_W),
  .DEC_MASK(DEC_MASK), .DEC_MATCH(DEC_MATCH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_io(mem_io), .wr_n(wr_n),
  .addr_q(addr_q), .port_q(port_q)
);

// File: tb/io_out_latch_bank_tb.sv
`timescale 1ns/1ps
module io_out_latch_bank_tb;
  logic        clk;
  logic        rst_n;
  logic        ale;
  logic        mem_io;
  logic        wr_n;
  logic [15:0] ad;
  logic [63:0] port_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  logic [7:0]  m_port [8];
  logic [15:0] m_addr;
  logic [1:0]  m_sync;

  io_out_latch_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .mem_io(mem_io),
    .wr_n(wr_n), .ad(ad), .port_q(port_q)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Behavioural reference: ports respond at even addresses 8000h..800Eh in I/O cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00;
      m_addr <= 16'h0;
      for (int k = 0; k < 8; k++) m_port[k] <= 8'h00;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        if (ale) m_addr <= ad;
        if (!wr_n && !mem_io && m_addr[15] && !m_addr[0])
          m_port[int'(m_addr[3:1])] <= ad[7:0];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic bad;
      bad = 0;
      for (int k = 0; k < 8; k++)
        if (port_q[8*k +: 8] !== m_port[k]) bad = 1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL R7 model compare: actual %h expected %h%h%h%h%h%h%h%h", port_q,
                 m_port[7], m_port[6], m_port[5], m_port[4],
                 m_port[3], m_port[2], m_port[1], m_port[0]);
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int i);
    return port_q[8*i +: 8];
  endfunction

  // address phase, hold phase, write phase with a given data-phase bus word, release
  task automatic bus_write(input logic [15:0] addr, input logic [15:0] dword,
                           input logic mem, input logic strobe);
    @(negedge clk); ale = 1; ad = addr; mem_io = mem;
    @(negedge clk); ale = 0;
    @(negedge clk); ad = dword; wr_n = !strobe;
    @(negedge clk); wr_n = 1;
    @(negedge clk); ad = 16'h0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ale = 0; mem_io = 1; wr_n = 1; ad = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 during reset", port_q, 64'h0);
    rst_n = 1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", port_q, 64'h0);

    // R8 timing: value present right after the edge sampling wr_n low
    @(negedge clk); ale = 1; ad = 16'h8000; mem_io = 0;
    @(negedge clk); ale = 0;
    @(negedge clk); ad = 16'h00A5; wr_n = 0;
    check("R8 not before edge", port_q, 64'h0);
    @(negedge clk); wr_n = 1;
    check("R8 one edge later", {56'h0, pbyte(0)}, 64'hA5);
    @(negedge clk); ad = 16'h0;
    check("R6 only port 0 changed", port_q, 64'h0000_0000_0000_00A5);

    bus_write(16'h8002, 16'h003C, 0, 1);
    check("R4 8002h selects port 1", {56'h0, pbyte(1)}, 64'h3C);
    bus_write(16'h800E, 16'h0077, 0, 1);
    check("R4 800Eh selects port 7", {56'h0, pbyte(7)}, 64'h77);
    check("R6 port layout", port_q, 64'h7700_0000_0000_3CA5);

    bus_write(16'h8004, 16'h0011, 1, 1);
    check("R3 memory cycle ignored", port_q, 64'h7700_0000_0000_3CA5);
    bus_write(16'h8005, 16'h0022, 0, 1);
    check("R5 odd address ignored", port_q, 64'h7700_0000_0000_3CA5);
    bus_write(16'h0004, 16'h0033, 0, 1);
    check("R5 lower half ignored", port_q, 64'h7700_0000_0000_3CA5);

    // data phase carries a word that would miss the window as an address
    bus_write(16'h8006, 16'h000F, 0, 1);
    check("R2 held address decides", {56'h0, pbyte(3)}, 64'h0F);

    bus_write(16'h800A, 16'h0099, 0, 0);
    check("R9 no strobe no change", port_q, 64'h7700_0000_0F00_3CA5);

    check("R7 port 0 held", {56'h0, pbyte(0)}, 64'hA5);
    bus_write(16'hFFF0, 16'h005A, 0, 1);
    check("R4 upper bits ignored", {56'h0, pbyte(0)}, 64'h5A);
    check("R7 port 0 replaced", port_q, 64'h7700_0000_0F00_3C5A);

    for (int i = 0; i < 8; i++) begin
      bus_write(16'h8000 + 16'(2 * i), 16'h5500 + 16'(i * 17 + 1), 0, 1);
      check("R4 sweep", {56'h0, pbyte(i)}, 64'(i * 17 + 1));
    end
    repeat (5) @(negedge clk);
    check("R7 all held", port_q, 64'h7867_5645_3423_1201);

    rst_n = 0;
    @(negedge clk);
    check("R1 reset clears", port_q, 64'h0);
    cmp_on = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule